// File: doc/BRIEF.md
# Composite Energy Frame Broadcaster

This block packs a 16-bit composite word and sends it as a 32-bit serial frame to a set of downstream threshold-comparator cards. The word carries a 5-bit beam energy code together with an error flag and several test-command bits: a soft reset for the comparator cards, a system-under-test flag, two beam-information bits, two permit-line test enables and a 4-bit target card number. Every frame has a fixed header, the composite word, a toggle nibble and a 4-bit CRC. The same frame is driven on every output lane at once.

A frame starts on a frame tick, which nominally arrives once per millisecond. Bits leave MSB first, one bit for each bit strobe. The composite word is captured when the frame starts, so input changes during a frame have no effect on it. When the upstream energy link is reported lost, the block sends a fixed fail-safe word instead. While test mode is active, a test override value replaces the energy code.

Top module: `cef_broadcaster`

## Requirements
- R1: After synchronous reset every output lane is 0 and no frame is in progress. Bit strobes that arrive without a frame tick leave the lanes at 0.
- R2: A frame tick seen while idle starts a frame. Frame bit 31 appears on the lanes in the cycle after the tick. After k accepted bit strobes, frame bit 31-k is shown. After 32 strobes the lanes return to 0.
- R3: Frame bits 31:24 are the header 1001_0000.
- R4: Frame bits 23:8 are the composite word, laid out as follows: energy in bits 15:11, error in bit 10, card soft reset in bit 9, system under test in bit 8, unmaskable beam info in bit 7, maskable beam info in bit 6, unmaskable permit-line test enable in bit 5, maskable permit-line test enable in bit 4, and target card in bits 3:0.
- R5: Frame bit 7 is the toggle and frame bits 6:4 are 000. The first frame after reset carries toggle 0, and each later frame carries the inverse of the frame before it.
- R6: Frame bits 3:0 are the CRC with polynomial x^4+x+1 and a zero seed. It is computed over frame bits 31:4, MSB first.
- R7: While link_lost is 1 at frame start, the composite word is 0xFCC0. That is energy 31, error 1, beam info bits 7 and 6 set, and every other bit 0. This holds regardless of test mode or command inputs.
- R8: While test_mode is 1 and the link is present, the energy field takes ovr_energy.
- R9: While test_mode is 0, ovr_energy has no effect, and the energy field takes energy_code.
- R10: The frame content is fixed at frame start. Input changes during a frame do not alter it.
- R11: A frame tick that arrives while a frame is in progress is ignored. It causes no restart, no change to the toggle and no extra frame.
- R12: All NUM_RX lanes carry the same bit in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Starts a frame when idle |
| bit_strobe | input | 1 | Advances the frame by one bit |
| link_lost | input | 1 | Upstream energy reception lost; selects the fail-safe word |
| test_mode | input | 1 | Enables the energy override |
| energy_code | input | 5 | Converted beam energy code |
| ovr_energy | input | 5 | Test override energy value |
| err_flag | input | 1 | Energy error flag |
| card_reset | input | 1 | Soft-reset command to the comparator cards |
| under_test | input | 1 | System-under-test flag |
| beam_info_u | input | 1 | Unmaskable beam information |
| beam_info_m | input | 1 | Maskable beam information |
| line_test_u | input | 1 | Unmaskable permit-line test enable |
| line_test_m | input | 1 | Maskable permit-line test enable |
| target_card | input | 4 | Card number addressed by a permit-line test |
| ser_lines | output | NUM_RX | Serial frame, one identical lane per receiver |

## Verification
A wrong shift register or bit counter shows up as a misplaced header or a wrong CRC within the first frame. It can also make the lanes fail to drop to 0 exactly at the 32nd strobe. A stale toggle register appears on the second frame, because two consecutive frames would then carry the same toggle value. A composite word that is not latched, or a frame tick that is not masked while busy, corrupts the word or restarts the header within the same frame as the disturbing input.

// File: rtl/cef_pkg.sv
package cef_pkg;

    localparam int FRAME_BITS = 32;
    localparam int CRC_W      = 4;
    localparam int CRC_SPAN   = FRAME_BITS - CRC_W;
    localparam int ENERGY_W   = 5;
    localparam int CARD_W     = 4;
    localparam int WORD_W     = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    localparam logic [7:0]         FRAME_HDR = 8'b1001_0000;
    localparam logic [CRC_W-1:0]   CRC_POLY  = 4'b0011;   // x^4 + x + 1, top term implicit

    typedef struct packed {
        logic [ENERGY_W-1:0] energy;
        logic                err;
        logic                card_reset;
        logic                under_test;
        logic                beam_info_u;
        logic                beam_info_m;
        logic                line_test_u;
        logic                line_test_m;
        logic [CARD_W-1:0]   card;
    } comp_word_t;

    localparam comp_word_t BROKEN_WORD = '{
        energy:      '1,
        err:         1'b1,
        card_reset:  1'b0,
        under_test:  1'b0,
        beam_info_u: 1'b1,
        beam_info_m: 1'b1,
        line_test_u: 1'b0,
        line_test_m: 1'b0,
        card:        '0
    };

    typedef logic [FRAME_BITS-1:0] frame_t;

    function automatic logic [CRC_W-1:0] crc4_calc(input logic [CRC_SPAN-1:0] body);
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ body[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        return acc;
    endfunction

    function automatic frame_t frame_pack(input comp_word_t w, input logic tog);
        logic [CRC_SPAN-1:0] body;
        body = {FRAME_HDR, w, tog, 3'b000};
        return {body, crc4_calc(body)};
    endfunction

endpackage

// File: rtl/cef_word_build.sv
module cef_word_build
    import cef_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                link_lost,
    input  logic                test_mode,
    input  logic [ENERGY_W-1:0] energy_code,
    input  logic [ENERGY_W-1:0] ovr_energy,
    input  logic                err_flag,
    input  logic                card_reset,
    input  logic                under_test,
    input  logic                beam_info_u,
    input  logic                beam_info_m,
    input  logic                line_test_u,
    input  logic                line_test_m,
    input  logic [CARD_W-1:0]   target_card,
    output comp_word_t          word
);

    always_comb begin
        if (link_lost) begin
            word = BROKEN_WORD;
        end else begin
            word.energy      = test_mode ? ovr_energy : energy_code;
            word.err         = err_flag;
            word.card_reset  = card_reset;
            word.under_test  = under_test;
            word.beam_info_u = beam_info_u;
            word.beam_info_m = beam_info_m;
            word.line_test_u = line_test_u;
            word.line_test_m = line_test_m;
            word.card        = target_card;
        end
    end

    AST_OVR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && !link_lost) |-> (word.energy == energy_code)); // R9

    AST_FAILSAFE_CARD: assert property (@(posedge clk) disable iff (rst)
        link_lost |-> (word.card == '0 && word.err)); // R7

endmodule

// File: rtl/cef_serializer.sv
module cef_serializer
    import cef_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_tick,
    input  logic       bit_strobe,
    input  comp_word_t word,
    output logic       busy,
    output logic       serial_bit
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    frame_t           shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             tog;
    logic             start;

    assign start      = frame_tick && !busy;
    assign serial_bit = busy && shreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            busy    <= 1'b0;
            tog     <= 1'b0;
        end else if (start) begin
            shreg   <= frame_pack(word, tog);
            bit_cnt <= '0;
            busy    <= 1'b1;
            tog     <= ~tog;
        end else if (busy && bit_strobe) begin
            shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) busy <= 1'b0;
        end
    end

    AST_HDR_LOADED: assert property (@(posedge clk) disable iff (rst)
        start |=> (shreg[FRAME_BITS-1 -: 8] == FRAME_HDR)); // R3

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        start |=> (tog != $past(tog))); // R5

    AST_CRC_LOADED: assert property (@(posedge clk) disable iff (rst)
        start |=> (crc4_calc(shreg[FRAME_BITS-1:CRC_W]) == shreg[CRC_W-1:0])); // R6

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_strobe) |=> $stable(shreg)); // R10

    AST_TICK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && frame_tick && !(bit_strobe && bit_cnt == LAST_BIT)) |=> (busy && $stable(tog))); // R11

endmodule

// File: rtl/cef_fanout.sv
module cef_fanout #(
    parameter int NUM_LANES = 16
) (
    input  logic                 serial_bit,
    output logic [NUM_LANES-1:0] lanes
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lanes[g] = serial_bit;
    end

endmodule

// File: rtl/cef_broadcaster.sv
module cef_broadcaster
    import cef_pkg::*;
#(
    parameter int NUM_RX = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_tick,
    input  logic                bit_strobe,
    input  logic                link_lost,
    input  logic                test_mode,
    input  logic [ENERGY_W-1:0] energy_code,
    input  logic [ENERGY_W-1:0] ovr_energy,
    input  logic                err_flag,
    input  logic                card_reset,
    input  logic                under_test,
    input  logic                beam_info_u,
    input  logic                beam_info_m,
    input  logic                line_test_u,
    input  logic                line_test_m,
    input  logic [CARD_W-1:0]   target_card,
    output logic [NUM_RX-1:0]   ser_lines
);

    comp_word_t word;
    logic       busy;
    logic       serial_bit;

    cef_word_build u_word (
        .clk         (clk),
        .rst         (rst),
        .link_lost   (link_lost),
        .test_mode   (test_mode),
        .energy_code (energy_code),
        .ovr_energy  (ovr_energy),
        .err_flag    (err_flag),
        .card_reset  (card_reset),
        .under_test  (under_test),
        .beam_info_u (beam_info_u),
        .beam_info_m (beam_info_m),
        .line_test_u (line_test_u),
        .line_test_m (line_test_m),
        .target_card (target_card),
        .word        (word)
    );

    cef_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .bit_strobe (bit_strobe),
        .word       (word),
        .busy       (busy),
        .serial_bit (serial_bit)
    );

    cef_fanout #(.NUM_LANES(NUM_RX)) u_fan (
        .serial_bit (serial_bit),
        .lanes      (ser_lines)
    );

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ser_lines == '0)); // R2

    AST_LANES_AGREE: assert property (@(posedge clk) disable iff (rst)
        (ser_lines == '0) || (ser_lines == '1)); // R12

endmodule

// File: tb/cef_broadcaster_tb.sv
module cef_broadcaster_tb;

    localparam int NUM_RX = 16;

    typedef struct packed {
        logic        lost;
        logic        tm;
        logic [4:0]  ovr;
        logic [4:0]  en;
        logic        err;
        logic [5:0]  cmd;   // card_reset, under_test, beam_u, beam_m, test_u, test_m
        logic [3:0]  card;
        logic [15:0] exp_word;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{lost:1'b0, tm:1'b0, ovr:5'd0,  en:5'd5,  err:1'b0, cmd:6'b001000, card:4'd3,  exp_word:16'h2883},
        '{lost:1'b0, tm:1'b1, ovr:5'd17, en:5'd2,  err:1'b1, cmd:6'b010000, card:4'd15, exp_word:16'h8D0F},
        '{lost:1'b0, tm:1'b0, ovr:5'd31, en:5'd9,  err:1'b0, cmd:6'b100111, card:4'd10, exp_word:16'h4A7A},
        '{lost:1'b1, tm:1'b1, ovr:5'd4,  en:5'd0,  err:1'b0, cmd:6'b111111, card:4'd7,  exp_word:16'hFCC0},
        '{lost:1'b0, tm:1'b0, ovr:5'd0,  en:5'd31, err:1'b1, cmd:6'b111111, card:4'd15, exp_word:16'hFFFF},
        '{lost:1'b0, tm:1'b0, ovr:5'd0,  en:5'd0,  err:1'b0, cmd:6'b000000, card:4'd0,  exp_word:16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 1'b0, bit_strobe = 1'b0;
    logic link_lost = 1'b0, test_mode = 1'b0;
    logic [4:0] energy_code = '0, ovr_energy = '0;
    logic err_flag = 1'b0, card_reset = 1'b0, under_test = 1'b0;
    logic beam_info_u = 1'b0, beam_info_m = 1'b0, line_test_u = 1'b0, line_test_m = 1'b0;
    logic [3:0] target_card = '0;
    logic [NUM_RX-1:0] ser_lines;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic exp_tog = 1'b0;

    always #2.5 clk = ~clk;

    cef_broadcaster #(.NUM_RX(NUM_RX)) u_dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .bit_strobe(bit_strobe),
        .link_lost(link_lost), .test_mode(test_mode), .energy_code(energy_code),
        .ovr_energy(ovr_energy), .err_flag(err_flag), .card_reset(card_reset),
        .under_test(under_test), .beam_info_u(beam_info_u), .beam_info_m(beam_info_m),
        .line_test_u(line_test_u), .line_test_m(line_test_m), .target_card(target_card),
        .ser_lines(ser_lines)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Remainder of body * x^4 divided by x^4+x+1 (long division form)
    function automatic logic [3:0] ref_crc(input logic [27:0] body);
        logic [31:0] r;
        r = {body, 4'b0000};
        for (int i = 31; i >= 4; i--)
            if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
        return r[3:0];
    endfunction

    task automatic apply_vec(input vec_t v);
        link_lost   = v.lost;
        test_mode   = v.tm;
        ovr_energy  = v.ovr;
        energy_code = v.en;
        err_flag    = v.err;
        {card_reset, under_test, beam_info_u, beam_info_m, line_test_u, line_test_m} = v.cmd;
        target_card = v.card;
    endtask

    // mode 0: plain, 1: disturb inputs mid-frame, 2: extra tick mid-frame
    task automatic run_frame(input logic [15:0] exp_word, input int mode, input string tag);
        logic [31:0] got;
        bit lanes_ok;
        logic [27:0] exp_body;
        got = '0;
        lanes_ok = 1'b1;
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        for (int k = 0; k < 32; k++) begin
            if (ser_lines != '0 && ser_lines != '1) lanes_ok = 1'b0;
            got[31-k] = ser_lines[0];
            bit_strobe = 1'b1;
            if (mode == 1 && k == 6) apply_vec(VEC[4]);
            if (mode == 1 && k == 7) apply_vec(VEC[3]);
            if (mode == 2 && k == 9) frame_tick = 1'b1;
            @(negedge clk);
            bit_strobe = 1'b0;
            frame_tick = 1'b0;
            if (k == 15) begin
                repeat (2) @(negedge clk);  // idle gap without strobes
            end
        end
        exp_body = {8'h90, exp_word, exp_tog, 3'b000};
        check(got[31:24] == 8'h90, {"R3 header ", tag}, got[31:24], 8'h90);
        check(got[23:8] == exp_word, {"R4/R7/R8/R9/R10 word ", tag}, got[23:8], exp_word);
        check(got[7:4] == {exp_tog, 3'b000}, {"R5 toggle ", tag}, got[7:4], {exp_tog, 3'b000});
        check(got[3:0] == ref_crc(exp_body), {"R6 crc ", tag}, got[3:0], ref_crc(exp_body));
        check(lanes_ok, {"R12 lanes equal ", tag}, 32'(lanes_ok), 1);
        check(ser_lines == '0, {"R2 end low ", tag}, ser_lines, 0);
        exp_tog = ~exp_tog;
        if (mode == 2) begin
            repeat (3) @(negedge clk);
            check(ser_lines == '0, {"R11 no extra frame ", tag}, ser_lines, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ser_lines == '0, "R1 reset lines", ser_lines, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ser_lines == '0, "R1 idle after reset", ser_lines, 0);
        for (int i = 0; i < 4; i++) begin
            bit_strobe = 1'b1; @(negedge clk);
        end
        bit_strobe = 1'b0;
        check(ser_lines == '0, "R1 strobes without tick", ser_lines, 0);

        for (int i = 0; i < NV; i++) begin
            apply_vec(VEC[i]);
            run_frame(VEC[i].exp_word, 0, $sformatf("vec%0d", i));
        end

        // R9: override varies, test mode off
        apply_vec(VEC[0]);
        ovr_energy = 5'd22;
        run_frame(16'h2883, 0, "R9 ovr ignored");

        // R8: same inputs, test mode on -> energy 22
        test_mode = 1'b1;
        run_frame({5'd22, 11'h083}, 0, "R8 ovr used");

        // R7: lost link overrides override and commands
        link_lost = 1'b1;
        run_frame(16'hFCC0, 0, "R7 failsafe");

        // R10: inputs change during the frame
        apply_vec(VEC[2]);
        run_frame(16'h4A7A, 1, "R10 latched");

        // R11: tick while busy
        apply_vec(VEC[1]);
        run_frame(16'h8D0F, 2, "R11 tick busy");

        // R5: toggle continues across a back-to-back frame
        run_frame(16'h8D0F, 0, "R5 next frame");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule